// File: doc/BRIEF.md
# Capture/Reload 16-bit Timer-Counter

This block is a 16-bit up-counter that software controls through a small byte-wide register bus. It can count in two ways. It can count internal clock cycles divided down by a fixed prescale of twelve. It can also count falling edges on an external count pin. A second external pin acts as a trigger, and a falling edge on it does one of two things. In capture mode it copies the running count into a holding register. In reload mode it forces the count back to the value in that holding register.

When the count rolls over, the block either clears it to zero (capture mode) or reloads it from the holding register (reload mode). The rollover also sets a sticky overflow flag.

The block can also serve as a baud-rate source. When either of two clock-select bits is set, the counter always auto-reloads on rollover, the overflow flag stays quiet, and each rollover is sent out as a one-cycle tick on a receive and/or transmit tick output. The interrupt output is raised whenever either sticky flag is set.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset every register reads 0 and irq is low. Register addresses: 0 control, 1 count low byte, 2 count high byte, 3 holding low byte, 4 holding high byte. Control bits: 7 overflow flag, 6 trigger flag, 5 receive-tick select, 4 transmit-tick select, 3 trigger enable, 2 run, 1 external-count select, 0 capture mode.
- R2: With run=1 and external-count select=0, the count rises by one every 12 clock cycles; the first increment comes 12 edges after the edge that wrote run=1.
- R3: With run=1 and external-count select=1, each falling edge of countPin adds exactly one to the count, 3 clock edges after the pin falls. Internal prescaler ticks are then ignored.
- R4: With run=0 the count does not change on its own.
- R5: An increment from 0xFFFF sets the overflow flag. The count then becomes 0 in capture mode and the holding value in reload mode.
- R6: In capture mode with trigger enable=1, a trigPin falling edge copies the count into the holding register and sets the trigger flag.
- R7: In reload mode with trigger enable=1, a trigPin falling edge loads the count from the holding register and sets the trigger flag.
- R8: With trigger enable=0, trigPin edges change neither the holding register, the count nor the trigger flag.
- R9: When receive- or transmit-tick select is 1, rollover always reloads from the holding register and never sets the overflow flag. rxTick and txTick pulse for one cycle after each rollover, according to their select bits. A trigger edge then only sets the trigger flag.
- R10: irq is high exactly when the overflow flag or the trigger flag is 1.
- R11: A software write to a count or holding byte wins over a same-cycle hardware update of that byte. The other byte still takes the hardware value.
- R12: Software writes set or clear the flags. A hardware flag set in the same cycle as a software clear leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the addressed register (combinational) |
| countPin | input | 1 | External count input, falling-edge active |
| trigPin | input | 1 | Trigger input, falling-edge active |
| irq | output | 1 | Interrupt request |
| rxTick | output | 1 | Receive baud tick |
| txTick | output | 1 | Transmit baud tick |

## Verification
Counting is tried with a vector table of start values, holding values and mode bytes.

- A start value far from rollover confirms the prescale rate.
- A start value near 0xFFFF in capture mode and again in reload mode separates clear-to-zero from reload.
- A baud-mode vector shows reload happening without an overflow flag.
- A stopped vector shows that the count holds.

Directed tests then exercise the trigger pin in each mode, with trigger enable both on and off. They also drive external count edges over a long enough window that counting internal ticks by mistake would give a different result. Finally, they land software writes on the exact edge of a hardware reload, to separate per-byte write priority and hardware-set flag priority from the reverse.

// File: rtl/crt_pkg.sv
package crt_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNTLO = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CNTHI = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_HLDLO = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_HLDHI = 3'd4;

  // control bit positions
  localparam int unsigned B_OVF   = 7;
  localparam int unsigned B_TRGF  = 6;
  localparam int unsigned B_RXSEL = 5;
  localparam int unsigned B_TXSEL = 4;
  localparam int unsigned B_TRGEN = 3;
  localparam int unsigned B_RUN   = 2;
  localparam int unsigned B_EXTC  = 1;
  localparam int unsigned B_CAPM  = 0;

  typedef struct packed {
    logic incr;         // count advances this cycle
    logic reloadOnOvf;  // rollover loads holding value instead of zero
    logic capture;      // copy count into holding register
    logic trigReload;   // load count from holding register
  } dpStrobe_t;
endpackage

// File: rtl/crt_ctrl.sv
module crt_ctrl
  import crt_pkg::*;
#(
  parameter int unsigned PRESCALE = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  input  logic              countPin,
  input  logic              trigPin,
  input  logic              countAtMax,
  output dpStrobe_t         strobe,
  output logic [7:0]        ctrlReg,
  output logic              rxTick,
  output logic              txTick,
  output logic              irq
);
  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int unsigned NPINS = 2;

  logic [NPINS-1:0] pinsIn, pinSynced, pinPrev, pinFall;
  assign pinsIn = {trigPin, countPin};

  // synchroniser chain plus edge history, one per pin
  for (genvar p = 0; p < NPINS; p++) begin : gPin
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        chain      <= '1;
        pinPrev[p] <= 1'b1;
      end else begin
        chain      <= {chain[SYNC_STAGES-2:0], pinsIn[p]};
        pinPrev[p] <= chain[SYNC_STAGES-1];
      end
    end
    assign pinSynced[p] = chain[SYNC_STAGES-1];
    assign pinFall[p]   = pinPrev[p] & ~pinSynced[p];
  end

  logic run, extCount, capMode, trigEn, baud;
  assign run      = ctrlReg[B_RUN];
  assign extCount = ctrlReg[B_EXTC];
  assign capMode  = ctrlReg[B_CAPM];
  assign trigEn   = ctrlReg[B_TRGEN];
  assign baud     = ctrlReg[B_RXSEL] | ctrlReg[B_TXSEL];

  logic [PW-1:0] presc;
  logic prescWrap;
  assign prescWrap = (presc == PW'(PRESCALE - 1));

  always_ff @(posedge clk) begin
    if (!rstN || !run || extCount) presc <= '0;
    else if (prescWrap)            presc <= '0;
    else                           presc <= presc + 1'b1;
  end

  logic incr, ovfEvt, trigEvt, wrCtrl;
  assign incr    = run & ((~extCount & prescWrap) | (extCount & pinFall[0]));
  assign ovfEvt  = incr & countAtMax;
  assign trigEvt = trigEn & pinFall[1];
  assign wrCtrl  = regWrEn && (regAddr == ADDR_CTRL);

  always_comb begin
    strobe.incr        = incr;
    strobe.reloadOnOvf = baud | ~capMode;
    strobe.capture     = trigEvt & capMode & ~baud;
    strobe.trigReload  = trigEvt & ~capMode & ~baud;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      rxTick  <= 1'b0;
      txTick  <= 1'b0;
    end else begin
      if (wrCtrl) ctrlReg <= regWrData;
      // hardware sets override a same-cycle software clear
      if (ovfEvt && !baud) ctrlReg[B_OVF] <= 1'b1;
      if (trigEvt)         ctrlReg[B_TRGF] <= 1'b1;
      rxTick <= ovfEvt & ctrlReg[B_RXSEL];
      txTick <= ovfEvt & ctrlReg[B_TXSEL];
    end
  end

  assign irq = ctrlReg[B_OVF] | ctrlReg[B_TRGF];
endmodule

// File: rtl/crt_datapath.sv
module crt_datapath
  import crt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  input  dpStrobe_t         strobe,
  input  logic [7:0]        ctrlReg,
  output logic              countAtMax,
  output logic [7:0]        regRdData
);
  localparam int unsigned NBYTES = CNT_W / 8;

  logic [CNT_W-1:0] countVal, holdVal, hwCount, hwHold;

  assign countAtMax = &countVal;

  always_comb begin
    hwCount = countVal;
    if (strobe.trigReload)  hwCount = holdVal;
    else if (strobe.incr)   hwCount = countAtMax ? (strobe.reloadOnOvf ? holdVal : '0)
                                                 : countVal + 1'b1;
    hwHold = strobe.capture ? countVal : holdVal;
  end

  for (genvar b = 0; b < NBYTES; b++) begin : gByte
    logic wrCnt, wrHld;
    assign wrCnt = regWrEn && (regAddr == ADDR_CNTLO + ADDR_W'(b));
    assign wrHld = regWrEn && (regAddr == ADDR_HLDLO + ADDR_W'(b));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        countVal[b*8 +: 8] <= '0;
        holdVal[b*8 +: 8]  <= '0;
      end else begin
        countVal[b*8 +: 8] <= wrCnt ? regWrData : hwCount[b*8 +: 8];
        holdVal[b*8 +: 8]  <= wrHld ? regWrData : hwHold[b*8 +: 8];
      end
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_CTRL:  regRdData = ctrlReg;
      ADDR_CNTLO: regRdData = countVal[7:0];
      ADDR_CNTHI: regRdData = countVal[15:8];
      ADDR_HLDLO: regRdData = holdVal[7:0];
      ADDR_HLDHI: regRdData = holdVal[15:8];
      default:    regRdData = '0;
    endcase
  end
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
  import crt_pkg::*;
#(
  parameter int unsigned PRESCALE = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              countPin,
  input  logic              trigPin,
  output logic              irq,
  output logic              rxTick,
  output logic              txTick
);
  dpStrobe_t strobe;
  logic [7:0] ctrlReg;
  logic countAtMax;

  crt_ctrl #(.PRESCALE(PRESCALE), .SYNC_STAGES(2)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .countPin(countPin), .trigPin(trigPin),
    .countAtMax(countAtMax), .strobe(strobe), .ctrlReg(ctrlReg),
    .rxTick(rxTick), .txTick(txTick), .irq(irq)
  );

  crt_datapath #(.CNT_W(16)) uDp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .strobe(strobe), .ctrlReg(ctrlReg),
    .countAtMax(countAtMax), .regRdData(regRdData)
  );
endmodule

// File: rtl/crt_checker.sv
module crt_checker
  import crt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [7:0]        ctrlReg,
  input logic [15:0]       count,
  input logic              rxTick,
  input logic              txTick
);
  logic wrCtrl, wrCnt;
  assign wrCtrl = regWrEn && (regAddr == ADDR_CTRL);
  assign wrCnt  = regWrEn && (regAddr == ADDR_CNTLO || regAddr == ADDR_CNTHI);

  // R9: baud mode never raises the overflow flag
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[B_RXSEL] | ctrlReg[B_TXSEL]) && !ctrlReg[B_OVF] && !wrCtrl |=> !ctrlReg[B_OVF]);

  // R9: ticks only on selected outputs
  a_r9_rx_selected: assert property (@(posedge clk) disable iff (!rstN)
    rxTick |-> $past(ctrlReg[B_RXSEL]));
  a_r9_tx_selected: assert property (@(posedge clk) disable iff (!rstN)
    txTick |-> $past(ctrlReg[B_TXSEL]));

  // R4: stopped capture-mode counter holds its value
  a_r4_stopped_holds: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlReg[B_RUN] && ctrlReg[B_CAPM] && !wrCnt |=> $stable(count));

  // R12: trigger flag is sticky until software writes control
  a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReg[B_TRGF] && !wrCtrl |=> ctrlReg[B_TRGF]);
endmodule

bind cap_reload_timer crt_checker uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .ctrlReg(uCtrl.ctrlReg), .count(uDp.countVal),
  .rxTick(rxTick), .txTick(txTick)
);

// File: tb/tb_cap_reload_timer.sv
`timescale 1ns/100ps
module tb_cap_reload_timer;
  logic clk = 1'b0, rstN = 1'b0, regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0, regRdData;
  logic countPin = 1'b1, trigPin = 1'b1;
  logic irq, rxTick, txTick;
  int nChecks = 0, nFails = 0;

  always #2.5 clk = ~clk;

  cap_reload_timer dut (.*);

  typedef struct packed {
    logic [7:0]  ctl;
    logic [15:0] pre;
    logic [15:0] hold;
    logic [7:0]  ticks;
    logic [15:0] expCnt;
    logic        expOvf;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{8'h04, 16'h0000, 16'h0000, 8'd5, 16'h0005, 1'b0},  // R2 plain timing
    '{8'h05, 16'hFFFE, 16'h3333, 8'd3, 16'h0001, 1'b1},  // R5 capture-mode wrap to 0
    '{8'h04, 16'hFFFE, 16'h1234, 8'd3, 16'h1235, 1'b1},  // R5 reload-mode wrap
    '{8'h24, 16'hFFFF, 16'hAB00, 8'd2, 16'hAB01, 1'b0},  // R9 baud reload, no flag
    '{8'h00, 16'h4321, 16'h0000, 8'd4, 16'h4321, 1'b0}   // R4 stopped
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // called at a negedge; write lands on the next posedge, returns at following negedge
  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] d);
    regAddr = a; #0.5; d = regRdData;
  endtask

  task automatic rdCount(output logic [15:0] v);
    logic [7:0] lo, hi;
    rdReg(3'd1, lo); rdReg(3'd2, hi); v = {hi, lo};
  endtask

  task automatic rdHold(output logic [15:0] v);
    logic [7:0] lo, hi;
    rdReg(3'd3, lo); rdReg(3'd4, hi); v = {hi, lo};
  endtask

  task automatic setup(input logic [15:0] cnt, input logic [15:0] hld);
    wrReg(3'd0, 8'h00);
    wrReg(3'd1, cnt[7:0]); wrReg(3'd2, cnt[15:8]);
    wrReg(3'd3, hld[7:0]); wrReg(3'd4, hld[15:8]);
  endtask

  task automatic trigFall();  // ends at negedge after the acting edge
    trigPin = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic trigRelease();
    trigPin = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [15:0] v;
    logic [7:0] c;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdReg(3'd0, c); check("R1 ctrl", {8'h0, c}, 16'h0000);
    rdCount(v);     check("R1 count", v, 16'h0000);
    rdHold(v);      check("R1 hold", v, 16'h0000);
    check("R1 irq", {15'h0, irq}, 16'h0000);

    // table walk (R2, R4, R5, R9, R10)
    for (int i = 0; i < 5; i++) begin
      setup(VECS[i].pre, VECS[i].hold);
      wrReg(3'd0, VECS[i].ctl);
      repeat (12 * int'(VECS[i].ticks)) @(posedge clk);
      @(negedge clk);
      rdCount(v); check("R2/R5 count", v, VECS[i].expCnt);
      rdReg(3'd0, c); check("R5 ovf flag", {15'h0, c[7]}, {15'h0, VECS[i].expOvf});
      check("R10 irq", {15'h0, irq}, {15'h0, VECS[i].expOvf});
    end

    // R12 software clear
    wrReg(3'd0, 8'h00);
    rdReg(3'd0, c); check("R12 clear", {8'h0, c}, 16'h0000);
    check("R10 irq low", {15'h0, irq}, 16'h0000);

    // R3 external counting over 24+ cycles
    setup(16'h0000, 16'h0000);
    wrReg(3'd0, 8'h06);
    for (int k = 0; k < 3; k++) begin
      countPin = 1'b0; repeat (4) @(negedge clk);
      countPin = 1'b1; repeat (4) @(negedge clk);
    end
    rdCount(v); check("R3 ext count", v, 16'h0003);

    // R6 capture
    setup(16'h5A5A, 16'h0000);
    wrReg(3'd0, 8'h09);
    trigFall();
    rdHold(v); check("R6 capture", v, 16'h5A5A);
    rdReg(3'd0, c); check("R6 flag", {15'h0, c[6]}, 16'h0001);
    check("R10 irq trig", {15'h0, irq}, 16'h0001);
    trigRelease();

    // R8 trigger disabled
    setup(16'h1111, 16'h0000);
    wrReg(3'd0, 8'h01);
    trigFall();
    rdHold(v); check("R8 hold unchanged", v, 16'h0000);
    rdReg(3'd0, c); check("R8 no flag", {15'h0, c[6]}, 16'h0000);
    trigRelease();

    // R7 trigger reload
    setup(16'h0100, 16'h7777);
    wrReg(3'd0, 8'h08);
    trigFall();
    rdCount(v); check("R7 reload", v, 16'h7777);
    rdReg(3'd0, c); check("R7 flag", {15'h0, c[6]}, 16'h0001);
    trigRelease();

    // R12 hardware set beats same-edge software clear
    setup(16'h0100, 16'h7777);
    wrReg(3'd0, 8'h08);
    trigPin = 1'b0; repeat (2) @(negedge clk);
    wrReg(3'd0, 8'h08);
    rdReg(3'd0, c); check("R12 hw wins", {15'h0, c[6]}, 16'h0001);
    trigRelease();

    // R11 software byte write beats same-edge reload
    setup(16'h0100, 16'h7777);
    wrReg(3'd0, 8'h08);
    trigPin = 1'b0; repeat (2) @(negedge clk);
    wrReg(3'd1, 8'h42);
    rdCount(v); check("R11 byte priority", v, 16'h7742);
    trigRelease();

    // R9 transmit tick and trigger-only-flag in baud mode
    setup(16'hFFFF, 16'hFF00);
    wrReg(3'd0, 8'h14);
    repeat (12) @(posedge clk);
    @(negedge clk);
    check("R9 tx tick", {14'h0, rxTick, txTick}, 16'h0001);
    rdCount(v); check("R9 reload", v, 16'hFF00);
    @(negedge clk);
    check("R9 tick one cycle", {14'h0, rxTick, txTick}, 16'h0000);
    setup(16'h0005, 16'h9999);
    wrReg(3'd0, 8'h28);
    trigFall();
    rdCount(v); check("R9 trig no reload", v, 16'h0005);
    rdReg(3'd0, c); check("R9 trig flag", {15'h0, c[6]}, 16'h0001);
    trigRelease();

    finishRun();
  end
endmodule